// File: doc/BRIEF.md
# Configurable Parallel-to-Serial Transmitter

This block turns parallel words from core logic into a serial bit stream that runs at the high-speed clock rate, one bit per fast clock. It has three paths. The shift path sends words of 4, 6, 7, 8 or 10 bits. The DDR bypass path sends 2 bits per core word. The SDR bypass path sends 1 bit per core word.

Configuration is static. The path and the factor are taken from configuration inputs only while reset is asserted. An internal divide counter produces two strobes:
- a one-cycle load pulse that moves the held word into the shift register;
- a word-request strobe, one cycle earlier, that tells upstream logic when to present the next word.

The core clock is therefore modelled as a clock enable on the fast clock. In the bypass paths, two output data registers capture the low input bits directly. The DDR bit pair is given as a 2-bit vector per fast cycle, which avoids dual-edge logic.

Top module: `ser_tx_top`

## Requirements
- R1: `cfg_mode` and `cfg_factor` are sampled only while `rst` is high. Changes to them after reset is released have no effect on any output.
- R2: When `cfg_mode` is 0 or 3 (shift path), a `cfg_factor` of 4, 6, 7, 8 or 10 sets the factor N. Any other value gives N = 10.
- R3: In the shift path, `load_en` is high for exactly one fast cycle in every N. It is first high after the N-th rising edge following reset release, and after every N-th edge from then on.
- R4: In the shift path, `word_req` is high after edges k where k mod N = N-1, which is one cycle before each `load_en`. `din` is captured only at the edge that ends a `word_req` cycle, and `din` values at all other times have no effect on the output.
- R5: In the shift path, a captured word is sent most significant bit first. Only bits N-1 down to 0 are sent, one per cycle, starting the cycle after `load_en` is high. On the `load_en` cycle itself, the last bit of the previous word is still being shifted out.
- R6: In the shift path, `sdout` stays 0 from reset until the first word starts, which is after edge N+1.
- R7: With `cfg_mode` = 1 (DDR bypass), `word_req` is high from the first edge after reset on, and `load_en` stays 0. `ddr_pair` equals {din[1], din[0]} from the previous cycle, with bit 1 being the first half-cycle bit, and `sdout` equals `ddr_pair[1]`.
- R8: With `cfg_mode` = 2 (SDR bypass), the strobes behave as in R7. Both `ddr_pair` bits and `sdout` equal din[0] from the previous cycle.
- R9: In the shift path, both bits of `ddr_pair` equal `sdout`.
- R10: While `rst` is high, `sdout`, `ddr_pair`, `word_req` and `load_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial-rate clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_mode | input | 2 | 0/3 shift path, 1 DDR bypass, 2 SDR bypass |
| cfg_factor | input | 4 | Shift-path serialization factor |
| din | input | DATA_W (10) | Parallel word from core logic |
| word_req | output | 1 | Core-side enable: present a new word this cycle |
| load_en | output | 1 | One-cycle pulse that moves the held word into the shift register |
| sdout | output | 1 | Serial data bit |
| ddr_pair | output | 2 | Bit pair per fast cycle; bit 1 is the first half-cycle bit |

## Verification
A counter that drifts from its proper phase shows up at once at the strobes, because `word_req` and `load_en` are checked on every cycle against the arithmetic phase k mod N. A wrong hold or shift register state, such as a bad alignment, bit order or capture time, corrupts `sdout` within one word period. The bench compares every serial bit against the word the bench itself sent. A wrong configuration latch gives a wrong period or the wrong path, which is visible within about N cycles. The mid-run configuration change would show as a phase or path change in the following word.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int FACTOR_W = 4;
  localparam logic [FACTOR_W-1:0] FALLBACK_FACTOR = 4'd10;

  typedef enum logic [1:0] {
    PATH_SHIFT = 2'd0,
    PATH_DDR   = 2'd1,
    PATH_SDR   = 2'd2
  } path_e;

  function automatic path_e decode_path(input logic [1:0] m);
    case (m)
      2'd1:    return PATH_DDR;
      2'd2:    return PATH_SDR;
      default: return PATH_SHIFT;
    endcase
  endfunction

  function automatic logic [FACTOR_W-1:0] legal_factor(input logic [FACTOR_W-1:0] f);
    case (f)
      4'd4, 4'd6, 4'd7, 4'd8, 4'd10: return f;
      default:                      return FALLBACK_FACTOR;
    endcase
  endfunction
endpackage

// File: rtl/ser_tx_cfg.sv
module ser_tx_cfg
  import ser_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_mode,
  input  logic [FACTOR_W-1:0] cfg_factor,
  output path_e               path_q,
  output logic [FACTOR_W-1:0] factor_q
);
  // Configuration is captured only during reset and frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      path_q   <= decode_path(cfg_mode);
      factor_q <= legal_factor(cfg_factor);
    end
  end
endmodule

// File: rtl/ser_tx_cadence.sv
module ser_tx_cadence
  import ser_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                bypass,
  input  logic [FACTOR_W-1:0] factor,
  output logic                load_q,
  output logic                req_q
);
  logic [FACTOR_W-1:0] cnt_q;
  logic                wrap;
  logic                pre_wrap;

  assign wrap     = (cnt_q == factor - 1'b1);
  assign pre_wrap = (cnt_q == factor - 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (bypass) begin
      cnt_q  <= '0;
      load_q <= 1'b0;
      req_q  <= 1'b1;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      load_q <= wrap;
      req_q  <= pre_wrap;
    end
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic                load,
  input  logic [FACTOR_W-1:0] factor,
  input  logic [DATA_W-1:0]   din,
  output logic                msb
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] mask;
  int unsigned       align;

  assign mask  = (ONE << factor) - ONE;
  assign align = DATA_W - int'(factor);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sh_q   <= '0;
    end else begin
      if (capture) hold_q <= din & mask;
      if (load)    sh_q   <= hold_q << align;
      else         sh_q   <= sh_q << 1;
    end
  end

  assign msb = sh_q[DATA_W-1];
endmodule

// File: rtl/ser_tx_bypass.sv
module ser_tx_bypass
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  path_e             path,
  input  logic [DATA_W-1:0] din,
  output logic [1:0]        pair_q
);
  // Two output data registers; index 1 is the first half-cycle bit.
  for (genvar g = 0; g < 2; g++) begin : g_oreg
    logic src;
    assign src = (g == 1 && path == PATH_DDR) ? din[1] : din[0];
    always_ff @(posedge clk) begin
      if (rst)          pair_q[g] <= 1'b0;
      else if (capture) pair_q[g] <= src;
    end
  end
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [3:0]        cfg_factor,
  input  logic [DATA_W-1:0] din,
  output logic              word_req,
  output logic              load_en,
  output logic              sdout,
  output logic [1:0]        ddr_pair
);
  path_e               path_q;
  logic [FACTOR_W-1:0] factor_q;
  logic                bypass;
  logic                sh_msb;
  logic [1:0]          pair_q;

  ser_tx_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_factor(cfg_factor),
    .path_q(path_q), .factor_q(factor_q)
  );

  assign bypass = (path_q != PATH_SHIFT);

  ser_tx_cadence u_cad (
    .clk(clk), .rst(rst), .bypass(bypass), .factor(factor_q),
    .load_q(load_en), .req_q(word_req)
  );

  ser_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .capture(word_req && !bypass), .load(load_en),
    .factor(factor_q), .din(din), .msb(sh_msb)
  );

  ser_tx_bypass #(.DATA_W(DATA_W)) u_byp (
    .clk(clk), .rst(rst), .capture(word_req && bypass), .path(path_q),
    .din(din), .pair_q(pair_q)
  );

  assign sdout    = bypass ? pair_q[1] : sh_msb;
  assign ddr_pair = bypass ? pair_q : {2{sh_msb}};
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input logic                clk,
  input logic                rst,
  input path_e               path_q,
  input logic [FACTOR_W-1:0] factor_q,
  input logic [DATA_W-1:0]   din,
  input logic                word_req,
  input logic                load_en,
  input logic                sdout,
  input logic [1:0]          ddr_pair
);
  logic [FACTOR_W:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)          gap_q <= '0;
    else if (load_en) gap_q <= 1;
    else              gap_q <= gap_q + 1'b1;
  end

  // R3
  load_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (path_q == PATH_SHIFT && load_en) |-> (gap_q == {1'b0, factor_q}));

  // R4
  req_leads_load_chk: assert property (@(posedge clk) disable iff (rst)
    (path_q == PATH_SHIFT && word_req) |=> load_en);

  // R7
  ddr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (path_q == PATH_DDR && word_req) |=> (ddr_pair == $past(din[1:0])));

  // R8
  sdr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (path_q == PATH_SDR && word_req) |=> (ddr_pair == {2{$past(din[0])}}));

  // R7
  bypass_noload_chk: assert property (@(posedge clk) disable iff (rst)
    (path_q != PATH_SHIFT) |-> !load_en);

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(rst) |=> ($stable(factor_q) && $stable(path_q)));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!word_req && !load_en && !sdout && ddr_pair == 2'b00));
endmodule

bind ser_tx_top ser_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .path_q(path_q), .factor_q(factor_q), .din(din),
  .word_req(word_req), .load_en(load_en), .sdout(sdout), .ddr_pair(ddr_pair)
);

// File: tb/ser_tx_top_tb.sv
`timescale 1ns/1ps
module ser_tx_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic [3:0] cfg_factor = 4'd4;
  logic [9:0] din = '0;
  logic       word_req, load_en, sdout;
  logic [1:0] ddr_pair;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  ser_tx_top u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_factor(cfg_factor), .din(din),
    .word_req(word_req), .load_en(load_en), .sdout(sdout), .ddr_pair(ddr_pair)
  );

  function automatic logic [9:0] wgen(input int m, input int seed);
    return 10'((m * 173 + seed * 29 + 91) % 1024);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic [3:0] fac);
    @(negedge clk);
    rst = 1'b1;
    cfg_mode = mode;
    cfg_factor = fac;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "sdout in reset", int'(sdout), 0);
    chk("R10", "pair in reset", int'(ddr_pair), 0);
    chk("R10", "word_req in reset", int'(word_req), 0);
    chk("R10", "load_en in reset", int'(load_en), 0);
    rst = 1'b0;
    din = 10'h3ff;
  endtask

  // Shift path: n is the factor the requirements predict.
  task automatic run_shift(input int n, input int seed, input bit disturb);
    int total;
    total = 7 * n + 2;
    for (int k = 1; k <= total; k++) begin
      logic [9:0] w;
      int exp_out;
      @(negedge clk);
      exp_out = 0;
      if (k >= n + 1) begin
        w = wgen((k - 1) / n, seed);
        exp_out = int'(w[n - 1 - ((k - 1) % n)]);   // R5 MSB first
      end
      chk("R3", "load_en", int'(load_en), (k % n == 0) ? 1 : 0);
      chk("R4", "word_req", int'(word_req), (k % n == n - 1) ? 1 : 0);
      chk((k < n + 1) ? "R6" : "R5", "sdout", int'(sdout), exp_out);
      chk("R9", "ddr_pair", int'(ddr_pair), exp_out * 3);
      // R4: junk on din outside request cycles must be ignored
      if (word_req) din = wgen((k + 1) / n, seed);
      else          din = ~wgen(k + 7, seed + 3);
      if (disturb && k == total / 2) begin
        // R1: runtime config change must have no effect
        cfg_factor = 4'd4;
        cfg_mode   = 2'd1;
      end
    end
  endtask

  task automatic run_bypass(input bit ddr, input int seed);
    logic [9:0] prev;
    prev = '0;
    for (int k = 1; k <= 40; k++) begin
      int exp_pair;
      @(negedge clk);
      exp_pair = 0;
      if (k >= 2) exp_pair = ddr ? int'(prev[1:0]) : int'({prev[0], prev[0]});
      chk(ddr ? "R7" : "R8", "word_req", int'(word_req), 1);
      chk(ddr ? "R7" : "R8", "load_en", int'(load_en), 0);
      chk(ddr ? "R7" : "R8", "ddr_pair", int'(ddr_pair), exp_pair);
      chk(ddr ? "R7" : "R8", "sdout", int'(sdout), exp_pair >> 1);
      prev = wgen(k, seed) ^ 10'(k * 3);
      din = prev;
      if (k == 20) cfg_factor = 4'd7;   // R1 harmless here too
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin : main
    int facs[5] = '{4, 6, 7, 8, 10};
    int bad[4]  = '{0, 5, 9, 15};
    foreach (facs[i]) begin
      // R2 legal factors
      do_reset(2'd0, 4'(facs[i]));
      run_shift(facs[i], i, 1'b0);
    end
    foreach (bad[i]) begin
      // R2 fallback to 10
      do_reset(2'd0, 4'(bad[i]));
      run_shift(10, 11 + i, 1'b0);
    end
    // R2 mode 3 acts as shift path
    do_reset(2'd3, 4'd6);
    run_shift(6, 21, 1'b0);
    // R1 config changes after reset ignored
    do_reset(2'd0, 4'd7);
    run_shift(7, 22, 1'b1);
    do_reset(2'd1, 4'd8);
    run_bypass(1'b1, 30);
    do_reset(2'd2, 4'd6);
    run_bypass(1'b0, 31);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule